// File: doc/BRIEF.md
# Two-Address I2C Register and Memory Slave

This block is an I2C-compatible slave that sits on one SCL/SDA pair and responds to two different 7-bit device addresses. One address reaches a small register file meant for clock and control settings. The other reaches a larger byte-wide user memory. Both spaces use the same access protocol. A write carries a one-byte word address followed by any number of data bytes. A read returns bytes starting at the pointer the last access left behind. The pointer is shared by the two spaces, and each space interprets it modulo its own size.

The bus inputs pass through a two-stage synchronizer. START and STOP are recovered from SDA edges that occur while SCL is high. The slave never drives SDA high. It pulls the line low through an output-enable, which is used for acknowledge bits and for zero data bits. There is no clock stretching, no general-call response and no 10-bit addressing. Both stores are cleared by the synchronous reset.

Top module: `dual_id_i2c_slave`

## Requirements
- R1: After reset the SDA output-enable is low and every location of both spaces reads back as 0x00.
- R2: A START (SDA falling while SCL is high) begins a new address byte from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) ends the transfer and leaves SDA released.
- R3: An address byte whose upper seven bits are 1101111 selects the 16-byte register space, and 1010111 selects the 64-byte memory space. The slave acknowledges a matching address byte by pulling SDA low for the ninth SCL pulse. Bit 0 of the address byte gives the direction: 1 means read and 0 means write.
- R4: For any other device address the slave gives no acknowledge and keeps SDA released for all following bytes until the next START. Nothing is written during that time.
- R5: In a write, the slave acknowledges the word-address byte and every data byte. Each data byte is stored in the selected space at the current pointer. Only the low 4 bits (register space) or the low 6 bits (memory space) of the word address are used.
- R6: The pointer advances by one after each byte written or read, and wraps from the last location of the selected space back to 0.
- R7: A read returns bytes MSB first, starting from the current pointer. The pointer may come from a word address set just before a repeated START, or from where the previous access in that space stopped.
- R8: In a read, an acknowledge bit that the master drives low makes the slave send the next byte. A high acknowledge makes the slave release SDA and stay silent until the next START or STOP.
- R9: The SDA output-enable changes only while SCL is low.
- R10: The two spaces are independent: a write at an index in one space leaves the same index in the other space unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
The risky overlap is between a byte boundary and a bus condition. A repeated START can arrive right after the slave has acknowledged a write data byte, while the store write strobe from that byte is still pending. The bench provokes this by starting a register-space write and then switching to a memory-space write with a repeated START and no STOP. It then reads back both locations, so it can see that the first byte landed and the second transfer was decoded afresh. A second overlap is a read NACK followed by more clocked bits. The bench judges this at the port: the slave must stay released, so the master reads all ones.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVADR,
        PH_WORDADR,
        PH_WDATA,
        PH_ACKOUT,
        PH_RDATA,
        PH_MACK,
        PH_SKIP
    } ph_e;

    typedef enum logic {
        SP_REG,
        SP_MEM
    } space_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        space_e     sp;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] ptr_step(input logic [7:0] p, input int unsigned aw);
        logic [8:0] m;
        m = (9'd1 << aw) - 9'd1;
        return (p + 8'd1) & m[7:0];
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_dual_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_dual_fsm.sv
module i2c_dual_fsm
    import i2c_dual_pkg::*;
#(
    parameter logic [6:0] REG_ID = 7'b1101111,
    parameter logic [6:0] MEM_ID = 7'b1010111,
    parameter int REG_AW = 4,
    parameter int MEM_AW = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rd_byte,
    output ph_e        ph,
    output space_e     sp,
    output logic [7:0] ptr,
    output wr_req_t    wr,
    output logic       sda_oe
);
    ph_e        nxt;
    logic [3:0] cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       mack;
    int unsigned cur_aw;

    assign cur_aw = (sp == SP_REG) ? REG_AW : MEM_AW;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            nxt    <= PH_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            ptr    <= '0;
            sp     <= SP_REG;
            sda_oe <= 1'b0;
            mack   <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                ph     <= PH_DEVADR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                ph     <= PH_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.rise) begin
                case (ph)
                    PH_DEVADR, PH_WORDADR, PH_WDATA:
                        if (cnt < 4'd8) begin
                            rx_sh <= {rx_sh[6:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end
                    PH_MACK: mack <= ~ev.sda;
                    default: ;
                endcase
            end else if (ev.fall) begin
                case (ph)
                    PH_DEVADR:
                        if (cnt == 4'd8) begin
                            cnt <= '0;
                            if (rx_sh[7:1] == REG_ID || rx_sh[7:1] == MEM_ID) begin
                                sp     <= (rx_sh[7:1] == REG_ID) ? SP_REG : SP_MEM;
                                sda_oe <= 1'b1;
                                ph     <= PH_ACKOUT;
                                nxt    <= rx_sh[0] ? PH_RDATA : PH_WORDADR;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    PH_WORDADR:
                        if (cnt == 4'd8) begin
                            cnt    <= '0;
                            ptr    <= rx_sh;
                            sda_oe <= 1'b1;
                            ph     <= PH_ACKOUT;
                            nxt    <= PH_WDATA;
                        end
                    PH_WDATA:
                        if (cnt == 4'd8) begin
                            cnt     <= '0;
                            wr.en   <= 1'b1;
                            wr.sp   <= sp;
                            wr.addr <= ptr;
                            wr.data <= rx_sh;
                            ptr     <= ptr_step(ptr, cur_aw);
                            sda_oe  <= 1'b1;
                            ph      <= PH_ACKOUT;
                            nxt     <= PH_WDATA;
                        end
                    PH_ACKOUT:
                        if (nxt == PH_RDATA) begin
                            tx_sh  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            cnt    <= '0;
                            ph     <= PH_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            ph     <= nxt;
                        end
                    PH_RDATA:
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            mack   <= 1'b0;
                            ptr    <= ptr_step(ptr, cur_aw);
                            ph     <= PH_MACK;
                        end else begin
                            cnt    <= cnt + 4'd1;
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    PH_MACK:
                        if (mack) begin
                            tx_sh  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            cnt    <= '0;
                            ph     <= PH_RDATA;
                        end else begin
                            ph <= PH_SKIP;
                        end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_dual_store.sv
module i2c_dual_store
    import i2c_dual_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int MEM_AW = 6,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr,
    input  space_e        rd_sp,
    input  logic [PW-1:0] rd_ptr,
    output logic [7:0]    rd_data
);
    localparam int REG_N = 1 << REG_AW;
    localparam int MEM_N = 1 << MEM_AW;

    logic [7:0] regs [REG_N];
    logic [7:0] mem  [MEM_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) regs[i] <= '0;
            for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
        end else if (wr.en) begin
            if (wr.sp == SP_REG) regs[wr.addr[REG_AW-1:0]] <= wr.data;
            else                 mem[wr.addr[MEM_AW-1:0]]  <= wr.data;
        end
    end

    assign rd_data = (rd_sp == SP_REG) ? regs[rd_ptr[REG_AW-1:0]]
                                       : mem[rd_ptr[MEM_AW-1:0]];
endmodule

// File: rtl/dual_id_i2c_slave.sv
module dual_id_i2c_slave
    import i2c_dual_pkg::*;
#(
    parameter logic [6:0] REG_ID = 7'b1101111,
    parameter logic [6:0] MEM_ID = 7'b1010111,
    parameter int REG_AW = 4,
    parameter int MEM_AW = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PW = (MEM_AW > REG_AW) ? MEM_AW : REG_AW;

    bus_ev_t    ev;
    ph_e        ph;
    space_e     sp;
    logic [7:0] ptr;
    logic [7:0] rd_byte;
    wr_req_t    wr_req;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_dual_fsm #(
        .REG_ID (REG_ID),
        .MEM_ID (MEM_ID),
        .REG_AW (REG_AW),
        .MEM_AW (MEM_AW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (rd_byte),
        .ph      (ph),
        .sp      (sp),
        .ptr     (ptr),
        .wr      (wr_req),
        .sda_oe  (sda_oe)
    );

    i2c_dual_store #(
        .REG_AW (REG_AW),
        .MEM_AW (MEM_AW),
        .PW     (PW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .rd_sp   (sp),
        .rd_ptr  (ptr[PW-1:0]),
        .rd_data (rd_byte)
    );
endmodule

// File: rtl/i2c_dual_chk.sv
module i2c_dual_chk
    import i2c_dual_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input bus_ev_t ev,
    input ph_e     ph,
    input wr_req_t wr,
    input logic    sda_oe
);
    p_start_release_r2: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe);

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (ph == PH_IDLE && !sda_oe));

    p_skip_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SKIP) |-> !sda_oe);

    p_skip_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SKIP) |-> !wr.en);

    p_write_acked_r5: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (sda_oe && ph == PH_ACKOUT));

    p_oe_rise_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);
endmodule

bind dual_id_i2c_slave i2c_dual_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .ph     (ph),
    .wr     (wr_req),
    .sda_oe (sda_oe)
);

// File: tb/tb_dual_id_i2c_slave.sv
`timescale 1ns/1ps
module tb_dual_id_i2c_slave;
    localparam int Q = 6;
    localparam logic [6:0] ID_REG = 7'b1101111;
    localparam logic [6:0] ID_MEM = 7'b1010111;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    assign sda_bus = sda_m & ~sda_oe;

    dual_id_i2c_slave dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    int  total = 0;
    int  bad = 0;
    int  viol = 0;
    bit  done = 0;
    logic [7:0] rmod [16];
    logic [7:0] mmod [64];
    int  mptr = 0;
    logic [7:0] wbuf [8];
    logic oe_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst && scl_m && (sda_oe != oe_prev)) viol++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q / 2);
        b = sda_bus;  hold(Q - Q / 2);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~ack);
    endtask

    function automatic int depth(input bit m);
        return m ? 64 : 16;
    endfunction

    function automatic logic [6:0] dev_id(input bit m);
        return m ? ID_MEM : ID_REG;
    endfunction

    function automatic logic [7:0] model_rd(input bit m, input int idx);
        return m ? mmod[idx % 64] : rmod[idx % 16];
    endfunction

    task automatic do_write(input bit m, input logic [7:0] a, input int n);
        bit ack;
        bus_start();
        wbyte({dev_id(m), 1'b0}, ack);
        check(ack, "R3 devaddr ack", {7'd0, ack}, 8'd1);
        wbyte(a, ack);
        check(ack, "R5 wordaddr ack", {7'd0, ack}, 8'd1);
        mptr = int'(a) % depth(m);
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack);
            check(ack, "R5 data ack", {7'd0, ack}, 8'd1);
            if (m) mmod[mptr] = wbuf[i]; else rmod[mptr] = wbuf[i];
            mptr = (mptr + 1) % depth(m);
        end
        bus_stop();
        check(sda_oe == 1'b0, "R2 released after stop", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic do_read(input bit m, input bit set_a, input logic [7:0] a, input int n, input string tag);
        bit ack;
        logic [7:0] v;
        bus_start();
        if (set_a) begin
            wbyte({dev_id(m), 1'b0}, ack);
            check(ack, "R3 devaddr ack", {7'd0, ack}, 8'd1);
            wbyte(a, ack);
            check(ack, "R5 wordaddr ack", {7'd0, ack}, 8'd1);
            mptr = int'(a) % depth(m);
            bus_start();
        end
        wbyte({dev_id(m), 1'b1}, ack);
        check(ack, "R3 read devaddr ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            check(v == model_rd(m, mptr), tag, v, model_rd(m, mptr));
            mptr = (mptr + 1) % depth(m);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] v;
        bit m;
        logic [7:0] a;
        int n;
        void'($urandom(32'h5EED_1C2));
        for (int i = 0; i < 16; i++) rmod[i] = 8'h00;
        for (int i = 0; i < 64; i++) mmod[i] = 8'h00;

        rst = 1'b1;
        hold(5);
        rst = 1'b0;
        hold(4);
        check(sda_oe == 1'b0, "R1 reset oe", {7'd0, sda_oe}, 8'd0);
        do_read(1'b0, 1'b1, 8'h00, 4, "R1 reg cleared");
        do_read(1'b1, 1'b1, 8'h3C, 2, "R1 mem cleared");

        // R10: same index in both spaces
        wbuf[0] = 8'hA5; do_write(1'b0, 8'h05, 1);
        wbuf[0] = 8'h5A; do_write(1'b1, 8'h05, 1);
        do_read(1'b0, 1'b1, 8'h05, 1, "R10 reg kept");
        do_read(1'b1, 1'b1, 8'h05, 1, "R10 mem kept");

        // R6: wrap at the end of each space, upper word-address bits dropped
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; do_write(1'b0, 8'hFF, 2);
        do_read(1'b0, 1'b1, 8'h0F, 2, "R6 reg wrap");
        wbuf[0] = 8'hD1; wbuf[1] = 8'hD2; wbuf[2] = 8'hD3; do_write(1'b1, 8'h3F, 3);
        do_read(1'b1, 1'b1, 8'h7F, 3, "R6 mem wrap");

        // R2: repeated START right after a data-byte acknowledge
        bus_start();
        wbyte({ID_REG, 1'b0}, ack); check(ack, "R2 first devaddr", {7'd0, ack}, 8'd1);
        wbyte(8'h03, ack);          check(ack, "R2 first wordaddr", {7'd0, ack}, 8'd1);
        wbyte(8'h11, ack);          check(ack, "R2 first data", {7'd0, ack}, 8'd1);
        rmod[3] = 8'h11;
        bus_start();
        wbyte({ID_MEM, 1'b0}, ack); check(ack, "R2 restart devaddr", {7'd0, ack}, 8'd1);
        wbyte(8'h07, ack);          check(ack, "R2 restart wordaddr", {7'd0, ack}, 8'd1);
        wbyte(8'h22, ack);          check(ack, "R2 restart data", {7'd0, ack}, 8'd1);
        mmod[7] = 8'h22;
        bus_stop();
        check(sda_oe == 1'b0, "R2 stop release", {7'd0, sda_oe}, 8'd0);
        do_read(1'b0, 1'b1, 8'h03, 1, "R2 reg landed");
        do_read(1'b1, 1'b1, 8'h07, 1, "R2 mem landed");

        // R4: foreign device address, write then read attempt
        bus_start();
        wbyte({7'b1010000, 1'b0}, ack); check(!ack, "R4 no devaddr ack", {7'd0, ack}, 8'd0);
        wbyte(8'h02, ack);              check(!ack, "R4 no wordaddr ack", {7'd0, ack}, 8'd0);
        wbyte(8'h77, ack);              check(!ack, "R4 no data ack", {7'd0, ack}, 8'd0);
        bus_stop();
        bus_start();
        wbyte({7'b1101110, 1'b1}, ack); check(!ack, "R4 no read ack", {7'd0, ack}, 8'd0);
        rbyte(v, 1'b0);                 check(v == 8'hFF, "R4 bus released", v, 8'hFF);
        bus_stop();
        do_read(1'b0, 1'b1, 8'h02, 1, "R4 reg untouched");

        // R8: master NACK ends the read; later bits stay released
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; do_write(1'b1, 8'h10, 2);
        bus_start();
        wbyte({ID_MEM, 1'b0}, ack); wbyte(8'h10, ack);
        bus_start();
        wbyte({ID_MEM, 1'b1}, ack); check(ack, "R8 devaddr ack", {7'd0, ack}, 8'd1);
        rbyte(v, 1'b0);             check(v == 8'h00, "R8 first byte", v, 8'h00);
        rbyte(v, 1'b0);             check(v == 8'hFF, "R8 silent after nack", v, 8'hFF);
        bus_stop();

        // R5 R6 R7: random writes, pointer-continuation reads, readbacks
        for (int t = 0; t < 24; t++) begin
            m = 1'($urandom % 2);
            a = 8'($urandom);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(m, a, n);
            do_read(m, 1'b0, 8'h00, 2, "R7 continue from pointer R6");
            do_read(m, 1'b1, a, n, "R7 readback R5");
        end

        check(viol == 0, "R9 oe changed with scl high", 8'(viol), 8'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule